// File: doc/BRIEF.md
# Pipelined Windowed Energy Sum

This block turns a set of parallel flash-ADC sample streams into a first-level trigger energy estimate. Every clock, each channel delivers one unsigned 12-bit sample. Each channel keeps the last `WIN` accepted samples in a shift register and holds their running total. That total is the digital equivalent of the gate of a charge-integrating converter. The channel totals then pass through a registered binary adder tree, which yields one energy sum for all channels. One new sum is produced per clock, with no gaps.

The input and output are a single stream with valid/ready flow control. A sample set is taken on a rising edge only when `in_valid` and `in_ready` are both high. `in_ready` follows `out_ready` directly. While `out_ready` is low, the whole pipeline freezes: no sample is taken, and every output, including its valid flag, holds its value. A cycle with `in_valid` low and `out_ready` high advances the pipeline with a bubble. The result valids are low until the window has been filled with `WIN` samples since reset. The per-channel totals and the energy sum come out as two valid-flagged streams. Both are governed by the same `out_ready`.

Top module: `esum_window_pipe`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is applied and right after it, `chan_valid` and `out_valid` are 0 and every channel sum and `out_sum` are 0.
- R2: On the edge that takes a sample set, each channel sum becomes the sum of that channel's last `WIN` taken samples. Channel i occupies bits `[i*SW +: SW]` of `in_samples` and bits `[i*WSW +: WSW]` of `chan_sums`. The updated value is visible on the ports right after that edge.
- R3: Until `WIN` sample sets have been taken since reset, the channel sums count the missing samples as zero and `chan_valid` stays 0. `chan_valid` goes to 1 on the edge that takes the `WIN`-th set.
- R4: `out_sum` and `out_valid` carry the sum of all channel sums and its valid flag. They follow `chan_sums`/`chan_valid` by `LEVELS = ceil(log2(NCH))` advancing edges.
- R5: With `in_valid` and `out_ready` held at 1, a new valid result appears on every clock once the pipeline is full.
- R6: An advancing edge with `in_valid` low leaves the window contents and the channel sums unchanged, and it drives `chan_valid` to 0 for that slot.
- R7: `in_ready` equals `out_ready`. While it is 0, samples presented with `in_valid` high are not taken, and all outputs keep their values.
- R8: The sums never overflow. Each channel sum is `WSW = SW + ceil(log2(WIN))` bits wide and `out_sum` is `WSW + ceil(log2(NCH))` bits wide. Full-scale input gives `WIN*4095` per channel and `NCH*WIN*4095` in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample set on `in_samples` is valid |
| in_ready | output | 1 | Block can take a sample set (equals `out_ready`) |
| in_samples | input | NCH*SW | One unsigned sample per channel, channel i at `[i*SW +: SW]` |
| chan_valid | output | 1 | Channel sums describe a full window |
| chan_sums | output | NCH*WSW | Per-channel window sums, channel i at `[i*WSW +: WSW]` |
| out_valid | output | 1 | `out_sum` is a valid energy sum |
| out_ready | input | 1 | Downstream accepts results; low freezes the pipeline |
| out_sum | output | WSW+ceil(log2(NCH)) | Energy sum across all channels |

## Verification
A channel sum is due right after the edge that takes its sample set. The matching energy sum is due `LEVELS` advancing edges later, which is two with four channels. Frozen edges with `out_ready` low do not count toward that delay. The bench drives inputs and samples outputs on the falling edge. After each rising edge it updates a reference model that holds the window history and a two-slot delay line for the total, and that advances only on edges where `out_ready` is high. Every output is then compared on the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/esum_pkg.sv
`timescale 1ns/1ps
package esum_pkg;
  // Width of a sum of CNT unsigned values each BITS wide.
  function automatic int grow_bits(input int bits, input int cnt);
    return bits + ((cnt > 1) ? $clog2(cnt) : 0);
  endfunction

  // Largest value of one full window of full-scale samples.
  function automatic longint window_max(input int bits, input int win);
    return longint'(win) * ((longint'(1) << bits) - 1);
  endfunction
endpackage

// File: rtl/esum_win_integ.sv
`timescale 1ns/1ps
module esum_win_integ #(
  parameter int SW  = 12,
  parameter int WIN = 8,
  parameter int WSW = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic [SW-1:0]  sample,
  output logic [WSW-1:0] win_sum
);
  import esum_pkg::*;
  localparam longint MAXV = window_max(SW, WIN);

  logic [SW-1:0] taps [WIN];

  // Running sum: add the entering sample, drop the one leaving the window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) taps[i] <= '0;
      win_sum <= '0;
    end else if (take) begin
      taps[0] <= sample;
      for (int i = 1; i < WIN; i++) taps[i] <= taps[i-1];
      win_sum <= win_sum + WSW'(sample) - WSW'(taps[WIN-1]);
    end
  end

  // R6/R7: a slot that takes nothing leaves the window sum untouched
  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(win_sum));

  // R8: the running sum stays within one full-scale window
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    longint'(win_sum) <= MAXV);
endmodule

// File: rtl/esum_adder_tree.sv
`timescale 1ns/1ps
module esum_adder_tree #(
  parameter int     NCH      = 4,
  parameter int     WSW      = 15,
  parameter int     ESW      = 17,
  parameter longint MAX_LEAF = 32760
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             in_valid,
  input  logic [NCH*WSW-1:0] in_sums,
  output logic             out_valid,
  output logic [ESW-1:0]   out_sum
);
  localparam int LEVELS = (NCH > 1) ? $clog2(NCH) : 0;
  localparam int PAD    = 1 << LEVELS;

  logic [PAD*ESW-1:0] leaves;

  // Zero-extend each channel sum; pad unused leaves with zero.
  for (genvar j = 0; j < PAD; j++) begin : g_leaf
    if (j < NCH) begin : g_real
      assign leaves[j*ESW +: ESW] = ESW'(in_sums[j*WSW +: WSW]);
    end else begin : g_pad
      assign leaves[j*ESW +: ESW] = '0;
    end
  end

  if (LEVELS == 0) begin : g_flat
    assign out_sum   = leaves[ESW-1:0];
    assign out_valid = in_valid;
  end else begin : g_tree
    logic [LEVELS-1:0] vpipe;

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int NIN  = PAD >> l;
      localparam int NOUT = NIN >> 1;
      logic [NIN*ESW-1:0]  src;
      logic [NOUT*ESW-1:0] q;

      if (l == 0) begin : g_src0
        assign src = leaves;
      end else begin : g_srcn
        assign src = g_lvl[l-1].q;
      end

      // One register stage per level of pairwise additions.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (adv) begin
          for (int k = 0; k < NOUT; k++)
            q[k*ESW +: ESW] <= src[2*k*ESW +: ESW] + src[(2*k+1)*ESW +: ESW];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vpipe <= '0;
      else if (adv) vpipe <= {vpipe[LEVELS-1:0], in_valid} >> 0;
    end

    assign out_sum   = g_lvl[LEVELS-1].q;
    assign out_valid = vpipe[LEVELS-1];
  end

  // R8: the total never exceeds the full-scale sum of all channels
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'(out_sum) <= longint'(NCH) * MAX_LEAF));
endmodule

// File: rtl/esum_window_pipe.sv
`timescale 1ns/1ps
module esum_window_pipe #(
  parameter int NCH = 4,
  parameter int SW  = 12,
  parameter int WIN = 8,
  parameter int WSW = esum_pkg::grow_bits(SW, WIN),
  parameter int ESW = esum_pkg::grow_bits(WSW, NCH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [NCH*SW-1:0]  in_samples,
  output logic               chan_valid,
  output logic [NCH*WSW-1:0] chan_sums,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ESW-1:0]     out_sum
);
  import esum_pkg::*;
  localparam int     FW       = $clog2(WIN + 1);
  localparam longint MAX_LEAF = window_max(SW, WIN);

  logic          adv;
  logic          take;
  logic [FW-1:0] fill;

  // The whole pipeline moves only when downstream accepts.
  assign adv      = out_ready;
  assign in_ready = adv;
  assign take     = in_valid && adv;

  // Counts taken sample sets up to a full window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill       <= '0;
      chan_valid <= 1'b0;
    end else if (adv) begin
      if (take && fill != FW'(WIN)) fill <= fill + 1'b1;
      chan_valid <= in_valid && (fill >= FW'(WIN - 1));
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    esum_win_integ #(.SW(SW), .WIN(WIN), .WSW(WSW)) u_integ (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .sample  (in_samples[c*SW +: SW]),
      .win_sum (chan_sums[c*WSW +: WSW])
    );
  end

  esum_adder_tree #(.NCH(NCH), .WSW(WSW), .ESW(ESW), .MAX_LEAF(MAX_LEAF)) u_tree (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .in_valid  (chan_valid),
    .in_sums   (chan_sums),
    .out_valid (out_valid),
    .out_sum   (out_sum)
  );

  // R3: channel sums are flagged valid only over a full window
  assert_valid_needs_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chan_valid |-> (fill == FW'(WIN)));

  // R7: a held result stays put while downstream stalls
  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

  // R7: no channel sum changes on a frozen edge
  assert_stall_chan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |=> ($stable(chan_sums) && $stable(chan_valid)));
endmodule

// File: tb/tb_esum_window_pipe.sv
`timescale 1ns/1ps
module tb_esum_window_pipe;
  localparam int CLK_PERIOD = 4;
  localparam int NCH = 4;
  localparam int SW  = 12;
  localparam int WIN = 8;
  localparam int WSW = 15;
  localparam int ESW = 17;
  localparam int LEVELS = 2;
  localparam int NVEC = 16;

  localparam logic [NCH*SW-1:0] VEC [NVEC] = '{
    48'h001_002_003_004, 48'h010_020_030_040, 48'hFFF_000_800_123,
    48'h555_AAA_0F0_F0F, 48'h100_200_300_400, 48'h7FF_001_FFE_002,
    48'h000_000_000_000, 48'hABC_DEF_123_456, 48'h321_654_987_CBA,
    48'h00F_0F0_F00_FFF, 48'h444_333_222_111, 48'h800_800_800_800,
    48'h0A0_B0B_0C0_D0D, 48'hFFF_FFF_000_000, 48'h135_246_357_468,
    48'h999_888_777_666
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [NCH*SW-1:0]  in_samples = '0;
  logic               chan_valid;
  logic [NCH*WSW-1:0] chan_sums;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic [ESW-1:0]     out_sum;

  int checks = 0;
  int errors = 0;

  // reference model state
  int     hist [NCH][WIN];
  int     fillm;
  bit     cv_e;
  longint cs_e [NCH];
  bit     l1v, ov;
  longint l1s, os;

  esum_window_pipe #(.NCH(NCH), .SW(SW), .WIN(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_samples(in_samples), .chan_valid(chan_valid), .chan_sums(chan_sums),
    .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < NCH; c++) begin
      cs_e[c] = 0;
      for (int i = 0; i < WIN; i++) hist[c][i] = 0;
    end
    fillm = 0; cv_e = 0; l1v = 0; ov = 0; l1s = 0; os = 0;
  endtask

  task automatic check_all(input string req);
    check(req, "in_ready", longint'(in_ready), longint'(out_ready));
    check(req, "chan_valid", longint'(chan_valid), longint'(cv_e));
    for (int c = 0; c < NCH; c++)
      check(req, $sformatf("chan_sum[%0d]", c), longint'(chan_sums[c*WSW +: WSW]), cs_e[c]);
    check(req, "out_valid", longint'(out_valid), longint'(ov));
    check(req, "out_sum", longint'(out_sum), os);
  endtask

  // Called at a falling edge: drive, pass one rising edge, model, check.
  task automatic apply(input bit v, input logic [NCH*SW-1:0] s, input bit rdy, input string req);
    longint tot;
    in_valid = v; in_samples = s; out_ready = rdy;
    @(posedge clk);
    if (rdy) begin
      tot = 0;
      for (int c = 0; c < NCH; c++) tot += cs_e[c];
      os = l1s; ov = l1v;
      l1s = tot; l1v = cv_e;
      if (v) begin
        for (int c = 0; c < NCH; c++) begin
          for (int i = WIN-1; i > 0; i--) hist[c][i] = hist[c][i-1];
          hist[c][0] = int'(s[c*SW +: SW]);
          cs_e[c] = 0;
          for (int i = 0; i < WIN; i++) cs_e[c] += hist[c][i];
        end
        if (fillm < WIN) fillm++;
        cv_e = (fillm == WIN);
      end else begin
        cv_e = 0;
      end
    end
    @(negedge clk);
    check_all(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    model_clear();
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nvalid;
    model_clear();
    do_reset();

    // R2/R4/R5: table of sample sets streamed back to back
    nvalid = 0;
    for (int k = 0; k < NVEC; k++) begin
      apply(1'b1, VEC[k], 1'b1, "R2");
      if (out_valid) nvalid++;
    end
    check("R5", "valid results in stream", nvalid, NVEC - (WIN - 1) - LEVELS);

    // R6: bubbles leave the window unchanged
    apply(1'b0, 48'hFFF_FFF_FFF_FFF, 1'b1, "R6");
    check("R6", "chan_valid after bubble", longint'(chan_valid), 0);
    apply(1'b0, 48'h123_123_123_123, 1'b1, "R6");
    apply(1'b1, VEC[3], 1'b1, "R6");

    // R7: stall with junk presented; nothing taken, outputs frozen
    for (int k = 0; k < 4; k++) apply(1'b1, 48'hEEE_EEE_EEE_EEE, 1'b0, "R7");
    check("R7", "in_ready while stalled", longint'(in_ready), 0);
    for (int k = 0; k < 4; k++) apply(1'b1, VEC[k], 1'b1, "R7");
    apply(1'b1, VEC[5], 1'b0, "R7");
    apply(1'b0, VEC[6], 1'b1, "R7");

    // R3: partial window after reset
    do_reset();
    for (int k = 0; k < WIN - 1; k++) apply(1'b1, VEC[k+1], 1'b1, "R3");
    check("R3", "chan_valid before full window", longint'(chan_valid), 0);
    apply(1'b1, VEC[0], 1'b1, "R3");
    check("R3", "chan_valid on full window", longint'(chan_valid), 1);

    // R8: full-scale input must not wrap
    for (int k = 0; k < WIN + LEVELS + 2; k++) apply(1'b1, 48'hFFF_FFF_FFF_FFF, 1'b1, "R8");
    check("R8", "full-scale channel sum", longint'(chan_sums[0 +: WSW]), WIN * 4095);
    check("R8", "full-scale total", longint'(out_sum), NCH * WIN * 4095);

    // R1: reset in mid-stream clears everything
    do_reset();
    apply(1'b1, VEC[9], 1'b1, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule